// File: doc/BRIEF.md
# Serial Bus Command Frame Encoder

This block assembles one outgoing command frame for the master side of a two-wire serial service bus. A request names a 2-bit slave id, a 21-bit byte address, a transfer size of 1, 2 or 4 bytes, a direction, and up to four write-data bytes. The block encodes the address in the shortest of three forms. The choice is made against a tracked last-address register. The block then appends a 4-bit CRC and presents the finished frame left-aligned in a 64-bit register, together with its bit count and a one-cycle done pulse. Data-poll, error-poll and terminate frames use the same datapath.

The CRC is computed serially, one bit per cycle. A frame of N bits before the CRC therefore takes N+1 cycles after the start strobe. The extra cycle is for an implied leading 1 bit. After the transfer completes, the surrounding controller reports the outcome with a result strobe. A successful access then becomes the new reference address. A failure, a terminate or a line break clears the reference.

Top module: `sbus_cmd_frame`

## Requirements
- R1: On done, `frame` holds the frame left-aligned from bit 63 and `frame_len` holds its length in bits, CRC included. Every bit below the frame is 0. An access frame carries these fields in order: id (2 bits), opcode, read flag (1 = read, 0 = write), address field, ds bit, write bytes, CRC (4 bits).
- R2: The absolute form (opcode 3'b100, 21-bit address field) is used when the reference is invalid, when the id differs from the stored id, or when the relative range is exceeded. After reset the reference is invalid.
- R3: When the id matches and the address minus the stored word address lies in -256..+255, the relative form is used: opcode 3'b101 and a 9-bit two's-complement difference.
- R4: When the id and the word address (addr[20:2]) equal the reference, the same form is used: opcode 2'b11 and a 2-bit byte-offset field.
- R5: `size_sel` 0 selects 1 byte (ds=0, low address bits unchanged). `size_sel` 1 selects 2 bytes (ds=1, bit 0 of the field cleared). `size_sel` 2 selects 4 bytes (ds=1, low two field bits forced to 01).
- R6: A write carries size bytes of `wdata`, byte `wdata[7:0]` first. A read carries no data bytes.
- R7: The CRC is the remainder of x^4+x+1 with zero initial value. It is taken over an implied leading 1 followed by all frame bits, MSB first.
- R8: `kind` 1 builds a data poll (id, 3'b010, CRC; 9 bits). `kind` 2 builds an error poll (id, 3'b011, CRC; 9 bits). `kind` 3 builds a terminate (id, 6'b111111, CRC; 12 bits). `kind` 0 builds an access.
- R9: A result strobe with ok set, after an access was the last frame started, stores {id, addr[20:2], 00} as the reference. Poll frames do not change which access is pending. A failed result invalidates the reference, as does a result after a terminate or a `line_break` pulse.
- R10: `done` is a single-cycle pulse that comes frame_len-3 clock edges after the edge that samples `start`. `busy` is high while the CRC runs. A `start` strobe seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin building a frame |
| kind | input | 2 | 0 access, 1 data poll, 2 error poll, 3 terminate |
| slave_id | input | 2 | Target slave id |
| addr | input | 21 | Byte address |
| size_sel | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes |
| is_read | input | 1 | 1 read, 0 write |
| wdata | input | 32 | Write bytes, [7:0] sent first |
| res_valid | input | 1 | Transfer outcome strobe |
| res_ok | input | 1 | Outcome was successful |
| line_break | input | 1 | Line break issued; invalidates reference |
| frame | output | 64 | Left-aligned frame |
| frame_len | output | 7 | Frame length in bits |
| done | output | 1 | Frame ready pulse |
| busy | output | 1 | Frame under construction |

## Verification
Some properties are checked by assertions on every cycle. Done is a single pulse that closes a busy period. No bit below the reported length is ever set. A line break always leaves the reference invalid. Other behaviour only shows up in the bench's scenarios against an independent model: the choice among same, relative and absolute forms, the ±256 range edges, and the size and data encodings. The same holds for the CRC, which the model checks by polynomial division. The scenarios also cover poll frames leaving the pending access alone, terminate and failure invalidation, and a start ignored while busy.

// File: rtl/sbus_cmd_frame.sv
module sbus_cmd_frame #(
  parameter int ADDR_W = 21,
  parameter int FRAME_W = 64,
  parameter int REL_W = 9,
  parameter logic [2:0] OP_ABS = 3'b100,
  parameter logic [2:0] OP_REL = 3'b101,
  parameter logic [1:0] OP_SAME = 2'b11,
  parameter logic [2:0] OP_DPOLL = 3'b010,
  parameter logic [2:0] OP_EPOLL = 3'b011,
  parameter logic [5:0] OP_TERM = 6'b111111,
  localparam int LEN_W = $clog2(FRAME_W + 1),
  localparam int KEY_W = ADDR_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         kind,
  input  logic [1:0]         slave_id,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         size_sel,
  input  logic               is_read,
  input  logic [31:0]        wdata,
  input  logic               res_valid,
  input  logic               res_ok,
  input  logic               line_break,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   frame_len,
  output logic               done,
  output logic               busy
);

  localparam logic [KEY_W-1:0] NO_REF = KEY_W'(1);

  logic [KEY_W-1:0]   last_q, pend_q;
  logic               pend_ok_q;
  logic [FRAME_W-1:0] m_q, msg;
  logic [LEN_W-1:0]   n_q, pos_q, n_c;
  logic [3:0]         crc_q, crc_nx;
  logic [FRAME_W:0]   wvec;
  logic               bit_now;

  function automatic logic [FRAME_W-1:0] put(input logic [FRAME_W-1:0] acc,
                                             input logic [31:0] v, input int w);
    logic [FRAME_W-1:0] mask;
    mask = (FRAME_W'(1) << w) - FRAME_W'(1);
    return (acc << w) | (FRAME_W'(v) & mask);
  endfunction

  logic [KEY_W-1:0]  key;
  logic signed [ADDR_W:0] diff;
  logic              hit_same, hit_rel, in_range, ds;
  logic [1:0]        low;
  int                nbytes;

  assign key      = {slave_id, addr[ADDR_W-1:2], 2'b00};
  assign diff     = $signed({1'b0, addr}) - $signed({1'b0, last_q[ADDR_W-1:0]});
  assign in_range = (diff[ADDR_W:REL_W-1] == '0) || (diff[ADDR_W:REL_W-1] == '1);
  assign hit_same = (last_q == key);
  assign hit_rel  = (last_q != NO_REF) && (last_q[KEY_W-1:ADDR_W] == slave_id) && in_range;
  assign ds       = (size_sel != 2'd0);
  assign nbytes   = (size_sel == 2'd0) ? 1 : (size_sel == 2'd1) ? 2 : 4;

  always_comb begin
    case (size_sel)
      2'd0:    low = addr[1:0];
      2'd1:    low = {addr[1], 1'b0};
      default: low = 2'b01;
    endcase
  end

  always_comb begin
    int nb;
    msg = '0;
    nb  = 0;
    msg = put(msg, {30'd0, slave_id}, 2);
    nb += 2;
    case (kind)
      2'd0: begin
        if (hit_same) begin
          msg = put(msg, {30'd0, OP_SAME}, 2);
          msg = put(msg, {31'd0, is_read}, 1);
          msg = put(msg, {30'd0, low}, 2);
          nb += 5;
        end else if (hit_rel) begin
          msg = put(msg, {29'd0, OP_REL}, 3);
          msg = put(msg, {31'd0, is_read}, 1);
          msg = put(msg, 32'({diff[REL_W-1:2], low}), REL_W);
          nb += 4 + REL_W;
        end else begin
          msg = put(msg, {29'd0, OP_ABS}, 3);
          msg = put(msg, {31'd0, is_read}, 1);
          msg = put(msg, 32'({addr[ADDR_W-1:2], low}), ADDR_W);
          nb += 4 + ADDR_W;
        end
        msg = put(msg, {31'd0, ds}, 1);
        nb += 1;
        for (int i = 0; i < 4; i++) begin
          if (!is_read && i < nbytes) begin
            msg = put(msg, {24'd0, wdata[8*i +: 8]}, 8);
            nb += 8;
          end
        end
      end
      2'd1: begin msg = put(msg, {29'd0, OP_DPOLL}, 3); nb += 3; end
      2'd2: begin msg = put(msg, {29'd0, OP_EPOLL}, 3); nb += 3; end
      default: begin msg = put(msg, {26'd0, OP_TERM}, 6); nb += 6; end
    endcase
    n_c = LEN_W'(nb);
  end

  assign wvec    = {1'b0, m_q} | ((FRAME_W + 1)'(1) << n_q);
  assign bit_now = wvec[pos_q];
  assign crc_nx  = {crc_q[2:0], 1'b0} ^ ({4{crc_q[3] ^ bit_now}} & 4'b0011);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      m_q       <= '0;
      n_q       <= '0;
      pos_q     <= '0;
      crc_q     <= '0;
      frame     <= '0;
      frame_len <= '0;
      pend_q    <= NO_REF;
      pend_ok_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        crc_q <= crc_nx;
        if (pos_q == '0) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          frame     <= ((m_q << 4) | FRAME_W'(crc_nx)) << (LEN_W'(FRAME_W - 4) - n_q);
          frame_len <= n_q + LEN_W'(4);
        end else begin
          pos_q <= pos_q - LEN_W'(1);
        end
      end else if (start) begin
        busy  <= 1'b1;
        m_q   <= msg;
        n_q   <= n_c;
        pos_q <= n_c;
        crc_q <= '0;
        if (kind == 2'd0) begin
          pend_q    <= key;
          pend_ok_q <= 1'b1;
        end else if (kind == 2'd3) begin
          pend_ok_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      last_q <= NO_REF;
    else if (line_break)
      last_q <= NO_REF;
    else if (res_valid)
      last_q <= (res_ok && pend_ok_q) ? pend_q : NO_REF;
  end

  a_r1_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((frame << frame_len) == '0));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r9_break_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    line_break |=> (last_q == NO_REF));

endmodule

// File: tb/sbus_cmd_frame_tb.sv
module sbus_cmd_frame_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, start = 0, is_read = 0;
  logic        res_valid = 0, res_ok = 0, line_break = 0;
  logic [1:0]  kind = 0, slave_id = 0, size_sel = 0;
  logic [20:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [63:0] frame;
  logic [6:0]  frame_len;
  logic        done, busy;

  int checks = 0, errors = 0;

  logic [22:0] bm_last = 23'd1, bm_pend = 23'd1;
  logic        bm_pend_ok = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbus_cmd_frame u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .slave_id(slave_id),
    .addr(addr), .size_sel(size_sel), .is_read(is_read), .wdata(wdata),
    .res_valid(res_valid), .res_ok(res_ok), .line_break(line_break),
    .frame(frame), .frame_len(frame_len), .done(done), .busy(busy));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] push(input logic [63:0] acc, input logic [31:0] v, input int w);
    return (acc << w) | (64'(v) & ((64'd1 << w) - 64'd1));
  endfunction

  function automatic logic [3:0] crc_div(input logic [63:0] m, input int n);
    logic [68:0] v;
    v = (69'(m) | (69'd1 << n)) << 4;
    for (int i = n + 4; i >= 4; i--)
      if (v[i]) v = v ^ (69'h13 << (i - 4));
    return v[3:0];
  endfunction

  task automatic model(input logic [1:0] k, input logic [1:0] id, input logic [20:0] a,
                       input logic [1:0] sz, input logic rd, input logic [31:0] wd,
                       output logic [63:0] fr, output logic [6:0] len);
    logic [63:0] m;
    int n, d, nby;
    logic [1:0] lo;
    m = 0; n = 0;
    nby = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    lo = (sz == 0) ? a[1:0] : (sz == 1) ? {a[1], 1'b0} : 2'b01;
    d = int'({11'd0, a}) - int'({11'd0, bm_last[20:0]});
    m = push(m, {30'd0, id}, 2); n += 2;
    if (k == 0) begin
      if (bm_last == {id, a[20:2], 2'b00}) begin
        m = push(m, 32'h3, 2); m = push(m, {31'd0, rd}, 1); m = push(m, {30'd0, lo}, 2); n += 5;
      end else if (bm_last != 23'd1 && bm_last[22:21] == id && d >= -256 && d <= 255) begin
        m = push(m, 32'h5, 3); m = push(m, {31'd0, rd}, 1);
        m = push(m, {23'd0, d[8:2], lo}, 9); n += 13;
      end else begin
        m = push(m, 32'h4, 3); m = push(m, {31'd0, rd}, 1);
        m = push(m, {11'd0, a[20:2], lo}, 21); n += 25;
      end
      m = push(m, {31'd0, (sz != 0)}, 1); n += 1;
      if (!rd) for (int i = 0; i < nby; i++) begin m = push(m, {24'd0, wd[8*i +: 8]}, 8); n += 8; end
    end else if (k == 1) begin m = push(m, 32'h2, 3); n += 3; end
    else if (k == 2) begin m = push(m, 32'h3, 3); n += 3; end
    else begin m = push(m, 32'h3f, 6); n += 6; end
    m = push(m, {28'd0, crc_div(m, n)}, 4); n += 4;
    fr = m << (64 - n);
    len = 7'(n);
  endtask

  task automatic build(input string req, input logic [1:0] k, input logic [1:0] id,
                       input logic [20:0] a, input logic [1:0] sz, input logic rd,
                       input logic [31:0] wd);
    logic [63:0] efr; logic [6:0] elen; int cyc;
    model(k, id, a, sz, rd, wd, efr, elen);
    @(negedge clk);
    kind = k; slave_id = id; addr = a; size_sel = sz; is_read = rd; wdata = wd; start = 1;
    @(negedge clk); start = 0; cyc = 1;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    chk({req, " frame"}, frame, efr);
    chk({req, " length"}, 64'(frame_len), 64'(elen));
    chk("R10 latency", 64'(cyc), 64'(elen) - 64'd2);
    if (k == 0) begin bm_pend = {id, a[20:2], 2'b00}; bm_pend_ok = 1; end
    else if (k == 3) bm_pend_ok = 0;
  endtask

  task automatic result(input logic ok);
    @(negedge clk); res_valid = 1; res_ok = ok;
    @(negedge clk); res_valid = 0; res_ok = 0;
    bm_last = (ok && bm_pend_ok) ? bm_pend : 23'd1;
  endtask

  task automatic t_reset();
    chk("R10 reset done", 64'(done), 0);
    chk("R10 reset busy", 64'(busy), 0);
    chk("R1 reset frame", frame, 0);
  endtask

  task automatic t_anchor();
    build("R2 absolute 4B read", 0, 1, 21'h12344, 2, 1, 0);
    result(1);
    build("R4 same form", 0, 1, 21'h12346, 0, 1, 0);
    chk("R7 known crc frame", frame, 64'h7C00_0000_0000_0000);
    chk("R4 same length", 64'(frame_len), 12);
    result(1);
  endtask

  task automatic t_relative();
    build("R3 relative 2B write", 0, 1, 21'h12384, 1, 0, 32'h0000_BEEF);
    chk("R6 write length", 64'(frame_len), 36);
    result(1);
    build("R3 relative -256", 0, 1, 21'h12284, 0, 1, 0);
    chk("R3 rel len", 64'(frame_len), 20);
    result(1);
    build("R3 relative +255", 0, 1, 21'h12383, 0, 1, 0);
    chk("R3 rel +255 len", 64'(frame_len), 20);
    result(1);
    build("R2 beyond +255", 0, 1, 21'h12480, 0, 1, 0);
    chk("R2 abs len", 64'(frame_len), 32);
    result(0);
    build("R9 after failure", 0, 1, 21'h12480, 0, 1, 0);
    chk("R9 fail invalid len", 64'(frame_len), 32);
    result(1);
    build("R2 other id", 0, 2, 21'h12480, 0, 1, 0);
    chk("R2 other id len", 64'(frame_len), 32);
  endtask

  task automatic t_sizes();
    build("R5 R6 4B write", 0, 3, 21'h1FFFFF, 2, 0, 32'hA1B2_C3D4);
    chk("R6 full frame length", 64'(frame_len), 64);
    build("R5 2B read", 0, 0, 21'h00003, 1, 1, 0);
    build("R5 1B write", 0, 0, 21'h00002, 0, 0, 32'h0000_005A);
  endtask

  task automatic t_polls();
    build("R2 access before poll", 0, 2, 21'h00100, 2, 1, 0);
    build("R8 data poll", 1, 2, 0, 0, 0, 0);
    chk("R8 dpoll len", 64'(frame_len), 9);
    build("R8 error poll", 2, 2, 0, 0, 0, 0);
    result(1);
    build("R9 poll keeps pending", 0, 2, 21'h00101, 0, 1, 0);
    chk("R9 same after poll", 64'(frame_len), 12);
    build("R8 terminate", 3, 2, 0, 0, 0, 0);
    chk("R8 term len", 64'(frame_len), 12);
    result(1);
    build("R9 after terminate", 0, 2, 21'h00101, 0, 1, 0);
    chk("R9 term invalid len", 64'(frame_len), 32);
  endtask

  task automatic t_break();
    build("R2 access", 0, 1, 21'h00040, 0, 1, 0);
    result(1);
    @(negedge clk); line_break = 1;
    @(negedge clk); line_break = 0;
    bm_last = 23'd1;
    build("R9 after break", 0, 1, 21'h00040, 0, 1, 0);
    chk("R9 break invalid len", 64'(frame_len), 32);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] efr; logic [6:0] elen; int ndone;
    model(0, 1, 21'h0ABCD, 2, 0, 32'h1122_3344, efr, elen);
    @(negedge clk);
    kind = 0; slave_id = 1; addr = 21'h0ABCD; size_sel = 2; is_read = 0; wdata = 32'h1122_3344; start = 1;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    kind = 1; slave_id = 3; start = 1;
    @(negedge clk); start = 0; ndone = 0;
    repeat (100) begin @(negedge clk); if (done) ndone++; end
    chk("R10 start while busy ignored frame", frame, efr);
    chk("R10 single done", 64'(ndone), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_anchor();
    t_relative();
    t_sizes();
    t_polls();
    t_break();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule